// File: doc/BRIEF.md
# Prioritized Level-Sensitive Interrupt Controller

This block gathers up to 128 level-sensitive interrupt sources, arranged in banks of 32, and presents one interrupt request to a processor. Each source can be masked, has a six-bit priority, and competes only when its priority is strictly better (numerically lower) than a global threshold. When an eligible source is active and the controller is idle, a sorting engine spends a fixed number of clock cycles choosing a winner. The winner is published in a sorted-result register and `irq_out` is raised.

If the source that started the sort drops during the sort window, or any mask bit changes during it, the published result is the all-ones spurious code. Software reads the sorted-result register, services the source or discards a spurious code, and then writes the acknowledge bit. Only after that write may a new sort begin.

Configuration goes through a simple 32-bit register port with a write strobe and a combinational read path. It also provides a soft reset with a completion flag, a revision word, an auto-idle bit and a protection bit. The auto-idle and protection bits are storage only.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, `irq_out` is 0. Every bank mask reads 0xFFFFFFFF. Every level register reads 0. The threshold (0x68, bits 7:0) reads 0xFF. The soft-reset status (0x14 bit 0) reads 1. The sorted-result register (0x40) reads 0xFFFFFFFF.
- R2: For bank n, the mask register at 0x84+0x20*n can be written directly. Writing ones to 0x88+0x20*n clears those mask bits, and writing ones to 0x8C+0x20*n sets them. Zero bits in either port leave the mask unchanged. A set mask bit disables its source.
- R3: Reading 0x98+0x20*n returns the raw source levels of bank n ANDed with the inverse of that bank's mask.
- R4: A source is eligible only if it is active, unmasked, and its priority (bits 7:2 of its level register at 0x100+4*i) is strictly below the threshold. With no eligible source, no sort starts and `irq_out` stays 0.
- R5: The winner is the eligible source with the lowest priority value, with ties going to the lowest source index. A valid result reads at 0x40 as the source number in bits 6:0, with bits 31:7 zero.
- R6: A sort starts on the first clock edge at which the controller is idle and an eligible source is active. `irq_out` rises on the SORT_CYCLES-th edge after that start edge (10 by default).
- R7: If the winning source is low at any of the SORT_CYCLES edges after the start edge, including the last, the result is 0xFFFFFFFF (bits 31:7 all ones = spurious). `irq_out` still rises.
- R8: If any mask bit changes value during the sort window, the result is the spurious code. A mask write that changes no bit does not make the result spurious.
- R9: `irq_out` stays 1 until a write of 1 to bit 0 of 0x48, and a write with bit 0 clear has no effect. The sorted-result register keeps its value after the acknowledge. If an eligible source is still active, the next sort starts on the following edge.
- R10: Writing 1 to bit 1 of 0x10 starts a soft reset. Bit 0 of 0x14 reads 0 from that write edge on. On the next edge, masks, levels, threshold, configuration bits, the sorter and the sorted result return to their R1 values and `irq_out` falls. Bit 0 of 0x14 reads 1 one edge later.
- R11: 0x00 reads the revision as major number in bits 7:4 and minor number in bits 3:0 (default 0x50). Bit 0 of 0x10 and bit 0 of 0x4C read back what was written. A level register reads back only bits 7:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Raw level-sensitive source inputs, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Byte address of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The hardest cases to reach from the ports are the spurious outcomes. They need a disturbance inside the short sort window, placed at an exact edge. The bench counts edges from the moment it raises a source. It drops the source on the last edge of the window, and it issues mask writes in the middle of the window. In the middle-of-window case it compares a write that flips a bit against one that rewrites the same value. Random rounds with a narrow priority range and a low threshold force many ties and many sources that are active but not eligible. A reference function predicts each winner from the bench's own copy of masks and levels.

// File: rtl/lic_pkg.sv
// lic_pkg: shared constants and types for the level interrupt controller.
// Assumes a 10-bit byte address space and 32-bit register words.
package lic_pkg;

    localparam int ID_W        = 7;
    localparam int PRIO_W      = 6;
    localparam int BANK_W      = 32;
    localparam int BANK_STRIDE = 32;

    localparam logic [9:0] OFS_REV     = 10'h000;
    localparam logic [9:0] OFS_SYSCFG  = 10'h010;
    localparam logic [9:0] OFS_SYSSTAT = 10'h014;
    localparam logic [9:0] OFS_SORTED  = 10'h040;
    localparam logic [9:0] OFS_CTRL    = 10'h048;
    localparam logic [9:0] OFS_PROT    = 10'h04C;
    localparam logic [9:0] OFS_THR     = 10'h068;
    localparam logic [9:0] OFS_MASK    = 10'h084;
    localparam logic [9:0] OFS_MCLR    = 10'h088;
    localparam logic [9:0] OFS_MSET    = 10'h08C;
    localparam logic [9:0] OFS_PEND    = 10'h098;
    localparam logic [9:0] OFS_LVL     = 10'h100;

    localparam logic [31:0] SPUR_CODE  = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SORT = 2'd1,
        ST_HOLD = 2'd2
    } sort_st_t;

endpackage

// File: rtl/lic_regs.sv
// lic_regs: register file of the controller. Holds the bank masks, the
// per-source priorities, the threshold, the configuration bits and the
// soft-reset handshake. It decodes writes and drives the combinational
// read path. Assumes NUM_SRC is a multiple of 32 and at most 128.
module lic_regs
    import lic_pkg::*;
#(
    parameter int         NUM_SRC   = 96,
    parameter logic [3:0] REV_MAJOR = 4'd5,
    parameter logic [3:0] REV_MINOR = 4'd0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [9:0]                reg_addr,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    input  logic [NUM_SRC-1:0]        src_in,
    input  logic [31:0]               sort_result,
    output logic [NUM_SRC-1:0]        mask_q,
    output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic [7:0]                thresh_q,
    output logic                      ack_pulse,
    output logic                      mask_chg,
    output logic                      srst_q
);

    localparam int NB = NUM_SRC / BANK_W;

    logic [NUM_SRC-1:0] mask_d;
    logic [PRIO_W-1:0]  prio_q [NUM_SRC];
    logic               autoidle_q;
    logic               prot_q;
    logic               srst_dly_q;
    logic               done_q;
    logic [7:0]         lvl_idx;
    logic               lvl_hit;
    logic               wr_syscfg;

    assign lvl_idx   = reg_addr[9:2] - 8'd64;
    assign lvl_hit   = (reg_addr >= OFS_LVL) && (lvl_idx < 8'(NUM_SRC));
    assign wr_syscfg = reg_wr && (reg_addr == OFS_SYSCFG);
    assign ack_pulse = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[0];

    // Next mask value from direct, clear-port and set-port writes.
    always_comb begin
        mask_d = mask_q;
        if (srst_q) begin
            mask_d = '1;
        end else if (reg_wr) begin
            for (int b = 0; b < NB; b++) begin
                if (reg_addr == OFS_MASK + 10'(BANK_STRIDE * b))
                    mask_d[b*BANK_W +: BANK_W] = reg_wdata;
                if (reg_addr == OFS_MCLR + 10'(BANK_STRIDE * b))
                    mask_d[b*BANK_W +: BANK_W] = mask_q[b*BANK_W +: BANK_W] & ~reg_wdata;
                if (reg_addr == OFS_MSET + 10'(BANK_STRIDE * b))
                    mask_d[b*BANK_W +: BANK_W] = mask_q[b*BANK_W +: BANK_W] | reg_wdata;
            end
        end
    end

    assign mask_chg = (mask_d != mask_q);

    // Mask storage, all sources disabled out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= mask_d;
    end

    // One priority register per source, flattened for the arbiter.
    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_lvl
        // Capture the priority field of a write to this source's level register.
        always_ff @(posedge clk) begin
            if (!rst_n || srst_q)
                prio_q[gi] <= '0;
            else if (reg_wr && lvl_hit && (lvl_idx == 8'(gi)))
                prio_q[gi] <= reg_wdata[PRIO_W+1:2];
        end
        assign prio_flat[gi*PRIO_W +: PRIO_W] = prio_q[gi];
    end

    // Threshold, auto-idle and protection configuration bits.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_q) begin
            thresh_q   <= 8'hFF;
            autoidle_q <= 1'b0;
            prot_q     <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_THR)  thresh_q   <= reg_wdata[7:0];
            if (wr_syscfg)            autoidle_q <= reg_wdata[0];
            if (reg_addr == OFS_PROT) prot_q     <= reg_wdata[0];
        end
    end

    // Soft-reset request, its delayed copy and the completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_q     <= 1'b0;
            srst_dly_q <= 1'b0;
            done_q     <= 1'b1;
        end else begin
            srst_q     <= wr_syscfg && reg_wdata[1];
            srst_dly_q <= srst_q;
            if (wr_syscfg && reg_wdata[1]) done_q <= 1'b0;
            else if (srst_dly_q)           done_q <= 1'b1;
        end
    end

    // Combinational read-back of the addressed register.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_REV:     reg_rdata = {24'd0, REV_MAJOR, REV_MINOR};
            OFS_SYSCFG:  reg_rdata = {31'd0, autoidle_q};
            OFS_SYSSTAT: reg_rdata = {31'd0, done_q};
            OFS_SORTED:  reg_rdata = sort_result;
            OFS_PROT:    reg_rdata = {31'd0, prot_q};
            OFS_THR:     reg_rdata = {24'd0, thresh_q};
            default:     reg_rdata = '0;
        endcase
        for (int b = 0; b < NB; b++) begin
            if (reg_addr == OFS_MASK + 10'(BANK_STRIDE * b))
                reg_rdata = mask_q[b*BANK_W +: BANK_W];
            if (reg_addr == OFS_PEND + 10'(BANK_STRIDE * b))
                reg_rdata = src_in[b*BANK_W +: BANK_W] & ~mask_q[b*BANK_W +: BANK_W];
        end
        if (lvl_hit) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (lvl_idx == 8'(i))
                    reg_rdata = {24'd0, prio_q[i], 2'b00};
            end
        end
    end

endmodule

// File: rtl/lic_pick.sv
// lic_pick: combinational arbiter. It marks each source eligible when the
// source is active, unmasked and its priority is strictly below the
// threshold. It then picks the lowest priority value, with ties going to
// the lowest index. Assumes NUM_SRC fits in ID_W bits of index.
module lic_pick
    import lic_pkg::*;
#(
    parameter int NUM_SRC = 96
) (
    input  logic [NUM_SRC-1:0]        src_in,
    input  logic [NUM_SRC-1:0]        mask,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [7:0]                thresh,
    output logic                      any_elig,
    output logic [ID_W-1:0]           win_id
);

    logic [NUM_SRC-1:0] elig;
    logic [PRIO_W-1:0]  best;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_elig
        assign elig[gi] = src_in[gi] & ~mask[gi]
                        & ({2'b00, prio_flat[gi*PRIO_W +: PRIO_W]} < thresh);
    end

    // Scan upward, replacing the candidate only on a strictly better priority.
    always_comb begin
        any_elig = 1'b0;
        best     = '1;
        win_id   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!any_elig || (prio_flat[i*PRIO_W +: PRIO_W] < best))) begin
                any_elig = 1'b1;
                best     = prio_flat[i*PRIO_W +: PRIO_W];
                win_id   = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/lic_sort.sv
// lic_sort: sort-window sequencer. It latches the arbiter's winner at the
// start edge and watches SORT_CYCLES edges for a drop of that source or a
// mask change. It then publishes either the winner or the spurious code and
// holds the request until acknowledged. Assumes src_in is synchronous to clk.
module lic_sort
    import lic_pkg::*;
#(
    parameter int NUM_SRC     = 96,
    parameter int SORT_CYCLES = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               srst,
    input  logic               any_elig,
    input  logic [ID_W-1:0]    win_id,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               mask_chg,
    input  logic               ack,
    output logic               irq_out,
    output logic               busy,
    output logic [31:0]        result
);

    localparam int CNT_W = $clog2(SORT_CYCLES + 1);

    sort_st_t        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [ID_W-1:0]  win_q;
    logic             spur_q;
    logic             spur_now;

    assign spur_now = spur_q | ~src_in[win_q] | mask_chg;
    assign irq_out  = (state_q == ST_HOLD);
    assign busy     = (state_q == ST_SORT);

    // Sequencer: idle -> sort window -> hold until acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            win_q   <= '0;
            spur_q  <= 1'b0;
            result  <= SPUR_CODE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (any_elig) begin
                        state_q <= ST_SORT;
                        cnt_q   <= '0;
                        win_q   <= win_id;
                        spur_q  <= 1'b0;
                    end
                end
                ST_SORT: begin
                    if (cnt_q == CNT_W'(SORT_CYCLES - 1)) begin
                        state_q <= ST_HOLD;
                        result  <= spur_now ? SPUR_CODE : {{(32-ID_W){1'b0}}, win_q};
                    end else begin
                        cnt_q  <= cnt_q + 1'b1;
                        spur_q <= spur_now;
                    end
                end
                ST_HOLD: begin
                    if (ack) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lvl_irq_ctrl.sv
// lvl_irq_ctrl: top of the prioritized level-sensitive interrupt controller.
// It connects the register file, the arbiter and the sort sequencer.
// Assumes NUM_SRC is 96 or 128 (banks of 32) and synchronous source inputs.
module lvl_irq_ctrl
    import lic_pkg::*;
#(
    parameter int         NUM_SRC     = 96,
    parameter int         SORT_CYCLES = 10,
    parameter logic [3:0] REV_MAJOR   = 4'd5,
    parameter logic [3:0] REV_MINOR   = 4'd0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               reg_wr,
    input  logic [9:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq_out
);

    logic [NUM_SRC-1:0]        mask_vec;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [7:0]                thresh;
    logic                      ack_pulse;
    logic                      mask_chg;
    logic                      srst;
    logic                      any_elig;
    logic [ID_W-1:0]           win_id;
    logic                      sort_busy;
    logic [31:0]               sort_res;

    lic_regs #(
        .NUM_SRC  (NUM_SRC),
        .REV_MAJOR(REV_MAJOR),
        .REV_MINOR(REV_MINOR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .src_in     (src_in),
        .sort_result(sort_res),
        .mask_q     (mask_vec),
        .prio_flat  (prio_flat),
        .thresh_q   (thresh),
        .ack_pulse  (ack_pulse),
        .mask_chg   (mask_chg),
        .srst_q     (srst)
    );

    lic_pick #(
        .NUM_SRC(NUM_SRC)
    ) u_pick (
        .src_in   (src_in),
        .mask     (mask_vec),
        .prio_flat(prio_flat),
        .thresh   (thresh),
        .any_elig (any_elig),
        .win_id   (win_id)
    );

    lic_sort #(
        .NUM_SRC    (NUM_SRC),
        .SORT_CYCLES(SORT_CYCLES)
    ) u_sort (
        .clk     (clk),
        .rst_n   (rst_n),
        .srst    (srst),
        .any_elig(any_elig),
        .win_id  (win_id),
        .src_in  (src_in),
        .mask_chg(mask_chg),
        .ack     (ack_pulse),
        .irq_out (irq_out),
        .busy    (sort_busy),
        .result  (sort_res)
    );

endmodule

// File: rtl/lic_chk.sv
// lic_chk: protocol checker bound into lvl_irq_ctrl. Observes the request
// output, the sort window, the published result and the mask vector.
module lic_chk
    import lic_pkg::*;
#(
    parameter int NUM_SRC     = 96,
    parameter int SORT_CYCLES = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_out,
    input logic               busy,
    input logic               srst,
    input logic               reg_wr,
    input logic [9:0]         reg_addr,
    input logic               ack_bit,
    input logic [31:0]        result,
    input logic [NUM_SRC-1:0] mask
);

    logic        ack_seen;
    logic [15:0] busy_len;

    assign ack_seen = reg_wr && (reg_addr == OFS_CTRL) && ack_bit;

    // Length of the current run of sort-window cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                    busy_len <= '0;
        else if (!busy)                busy_len <= '0;
        else if (busy_len != 16'hFFFF) busy_len <= busy_len + 1'b1;
    end

    // R6: the request rises only after exactly SORT_CYCLES window cycles.
    a_r6_window_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> (busy_len == 16'(SORT_CYCLES)));

    // R9: the request holds until acknowledged or soft reset.
    a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !ack_seen && !srst) |=> irq_out);

    // R7: a published result is either a source number or the full spurious code.
    a_r7_result_code: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((result[31:7] == '0) || (result == SPUR_CODE)));

    // R5: a valid result names an existing source.
    a_r5_result_range: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && (result[31:7] == '0)) |-> (result < 32'(NUM_SRC)));

    // R10: soft reset drops the request and stops any sort.
    a_r10_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!irq_out && !busy));

    // R2: masks change only through register writes or soft reset.
    a_r2_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !srst) |=> $stable(mask));

endmodule

bind lvl_irq_ctrl lic_chk #(
    .NUM_SRC    (NUM_SRC),
    .SORT_CYCLES(SORT_CYCLES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_out (irq_out),
    .busy    (sort_busy),
    .srst    (srst),
    .reg_wr  (reg_wr),
    .reg_addr(reg_addr),
    .ack_bit (reg_wdata[0]),
    .result  (sort_res),
    .mask    (mask_vec)
);

// File: tb/lvl_irq_ctrl_tb.sv
module lvl_irq_ctrl_tb;

    localparam int NS = 96;
    localparam int NB = NS / 32;
    localparam int SC = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_in = '0;
    logic          reg_wr = 1'b0;
    logic [9:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_out;

    int n_tests = 0;
    int n_fail  = 0;

    bit m_mask [NS];
    int m_prio [NS];
    int m_thr;

    lvl_irq_ctrl #(.NUM_SRC(NS), .SORT_CYCLES(SC)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    always #2 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    function automatic logic [31:0] bank_mask(input int b);
        logic [31:0] v;
        for (int i = 0; i < 32; i++) v[i] = m_mask[b*32+i];
        return v;
    endfunction

    task automatic mask_wr(input int b, input logic [31:0] v);
        wr(10'(10'h084 + 32*b), v);
        for (int i = 0; i < 32; i++) m_mask[b*32+i] = v[i];
    endtask

    task automatic mask_clr(input int b, input logic [31:0] v);
        wr(10'(10'h088 + 32*b), v);
        for (int i = 0; i < 32; i++) if (v[i]) m_mask[b*32+i] = 1'b0;
    endtask

    task automatic mask_set(input int b, input logic [31:0] v);
        wr(10'(10'h08C + 32*b), v);
        for (int i = 0; i < 32; i++) if (v[i]) m_mask[b*32+i] = 1'b1;
    endtask

    task automatic set_prio(input int s, input int p);
        wr(10'(10'h100 + 4*s), 32'(p << 2));
        m_prio[s] = p;
    endtask

    task automatic set_thr(input int t);
        wr(10'h068, 32'(t));
        m_thr = t;
    endtask

    task automatic ack();
        wr(10'h048, 32'h1);
    endtask

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin
            m_mask[i] = 1'b1;
            m_prio[i] = 0;
        end
        m_thr = 255;
    endtask

    // Reference winner: lowest priority value, then lowest index; -1 if none.
    function automatic int exp_win(input logic [NS-1:0] s);
        int w = -1;
        int bp = 0;
        for (int i = 0; i < NS; i++) begin
            if (s[i] && !m_mask[i] && (m_prio[i] < m_thr)) begin
                if (w < 0 || m_prio[i] < bp) begin
                    w = i;
                    bp = m_prio[i];
                end
            end
        end
        return w;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_0042));
        model_reset();
        ticks(3);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 irq", 32'(irq_out), 32'h0);
        for (int b = 0; b < NB; b++) chk_rd("R1 mask", 10'(10'h084 + 32*b), 32'hFFFF_FFFF);
        chk_rd("R1 level", 10'h100, 32'h0);
        chk_rd("R1 level last", 10'(10'h100 + 4*(NS-1)), 32'h0);
        chk_rd("R1 thr", 10'h068, 32'hFF);
        chk_rd("R1 sysstat", 10'h014, 32'h1);
        chk_rd("R1 sorted", 10'h040, 32'hFFFF_FFFF);

        // R11 revision and read-back
        chk_rd("R11 rev", 10'h000, 32'h50);
        wr(10'h04C, 32'h1);
        chk_rd("R11 prot", 10'h04C, 32'h1);
        wr(10'h010, 32'h1);
        chk_rd("R11 autoidle", 10'h010, 32'h1);
        wr(10'h11C, 32'hFFFF_FFFF);
        chk_rd("R11 level field", 10'h11C, 32'hFC);
        set_prio(7, 0);

        // R2 mask ports on bank 2
        mask_clr(2, 32'hF0);
        chk_rd("R2 clear port", 10'h0C4, 32'hFFFF_FF0F);
        mask_set(2, 32'h10);
        chk_rd("R2 set port", 10'h0C4, 32'hFFFF_FF1F);
        mask_clr(2, 32'h0);
        chk_rd("R2 zero write", 10'h0C4, 32'hFFFF_FF1F);
        mask_wr(2, 32'h1234_5678);
        chk_rd("R2 direct", 10'h0C4, 32'h1234_5678);
        mask_wr(2, 32'hFFFF_FFFF);

        // R3 pending with threshold 0 (R4: nothing eligible)
        set_thr(0);
        mask_wr(0, 32'hFFFF_0000);
        src_in[31:0]  = 32'h00FF_00FF;
        src_in[63:32] = 32'hFFFF_FFFF;
        chk_rd("R3 pend bank0", 10'h098, 32'h0000_00FF);
        chk_rd("R3 pend bank1", 10'h0B8, 32'h0);
        ticks(SC + 2);
        chk("R4 threshold zero blocks", 32'(irq_out), 32'h0);
        src_in = '0;
        mask_wr(0, 32'hFFFF_FFFF);

        // R4 threshold boundary: priority equal to threshold is ignored
        mask_clr(0, 32'h8);
        set_prio(3, 9);
        set_thr(9);
        src_in[3] = 1'b1;
        ticks(SC + 2);
        chk("R4 prio equal thr", 32'(irq_out), 32'h0);
        src_in = '0;
        set_thr(10);
        src_in[3] = 1'b1;
        ticks(SC + 1);
        chk("R4 prio below thr", 32'(irq_out), 32'h1);
        chk_rd("R5 sorted src3", 10'h040, 32'd3);
        src_in = '0;
        ack();
        mask_set(0, 32'h8);

        // R6/R9 timing and hold with source 40
        set_thr(255);
        mask_clr(1, 32'h100);
        set_prio(40, 5);
        src_in[40] = 1'b1;
        ticks(SC);
        chk("R6 irq low before window end", 32'(irq_out), 32'h0);
        tick();
        chk("R6 irq at window end", 32'(irq_out), 32'h1);
        chk_rd("R5 sorted src40", 10'h040, 32'd40);
        ticks(5);
        chk("R9 hold", 32'(irq_out), 32'h1);
        wr(10'h048, 32'h0);
        chk("R9 ack bit clear ignored", 32'(irq_out), 32'h1);
        ack();
        chk("R9 ack drops irq", 32'(irq_out), 32'h0);
        chk_rd("R9 sorted kept", 10'h040, 32'd40);
        ticks(SC);
        chk("R9 resort not early", 32'(irq_out), 32'h0);
        tick();
        chk("R9 resort completes", 32'(irq_out), 32'h1);
        src_in = '0;
        ack();
        ticks(SC + 2);
        chk("R9 idle without source", 32'(irq_out), 32'h0);

        // R5 tie break among sources 2..5
        mask_wr(0, 32'hFFFF_FFC3);
        set_prio(2, 4); set_prio(3, 2); set_prio(4, 2); set_prio(5, 3);
        src_in[5:2] = 4'hF;
        ticks(SC + 1);
        chk("R5 tie irq", 32'(irq_out), 32'h1);
        chk_rd("R5 tie lowest index", 10'h040, 32'd3);
        src_in = '0;
        ack();
        mask_wr(0, 32'hFFFF_FFFF);

        // R7 source drop mid-window
        src_in[40] = 1'b1;
        ticks(3);
        src_in[40] = 1'b0;
        ticks(SC + 1 - 3);
        chk("R7 irq on drop", 32'(irq_out), 32'h1);
        chk_rd("R7 spurious mid", 10'h040, 32'hFFFF_FFFF);
        ack();
        ticks(SC + 2);
        chk("R7 no resort", 32'(irq_out), 32'h0);

        // R7 source drop on the last window edge
        src_in[40] = 1'b1;
        ticks(SC);
        src_in[40] = 1'b0;
        tick();
        chk("R7 irq last edge", 32'(irq_out), 32'h1);
        chk_rd("R7 spurious last edge", 10'h040, 32'hFFFF_FFFF);
        ack();

        // R8 mask change mid-window, then an unchanged mask write
        src_in[40] = 1'b1;
        ticks(4);
        mask_clr(2, 32'h40);
        ticks(SC + 1 - 5);
        chk("R8 irq", 32'(irq_out), 32'h1);
        chk_rd("R8 spurious on mask change", 10'h040, 32'hFFFF_FFFF);
        src_in = '0;
        ack();
        src_in[40] = 1'b1;
        ticks(4);
        mask_clr(2, 32'h40);
        ticks(SC + 1 - 5);
        chk("R8 irq no change", 32'(irq_out), 32'h1);
        chk_rd("R8 same-value write valid", 10'h040, 32'd40);
        src_in = '0;
        ack();

        // R4/R5 random rounds
        for (int it = 0; it < 60; it++) begin
            logic [NS-1:0] pat;
            int e;
            src_in = '0;
            set_thr($urandom_range(1, 9));
            for (int k = 0; k < 8; k++) set_prio($urandom_range(0, NS-1), $urandom_range(0, 7));
            for (int b = 0; b < NB; b++) mask_wr(b, $urandom() | $urandom());
            for (int b = 0; b < NB; b++) pat[b*32 +: 32] = $urandom() & $urandom();
            e = exp_win(pat);
            src_in = pat;
            ticks(SC + 1);
            if (e >= 0) begin
                chk("R5 random irq", 32'(irq_out), 32'h1);
                chk_rd("R5 random winner", 10'h040, 32'(e));
                src_in = '0;
                ack();
            end else begin
                chk("R4 random none eligible", 32'(irq_out), 32'h0);
            end
        end
        src_in = '0;

        // R10 soft reset from the hold state
        set_thr(255);
        set_prio(3, 12);
        mask_wr(0, 32'hFFFF_FFFE);
        src_in[0] = 1'b1;
        ticks(SC + 1);
        chk("R10 precondition irq", 32'(irq_out), 32'h1);
        wr(10'h010, 32'h3);
        chk_rd("R10 status low", 10'h014, 32'h0);
        tick();
        chk("R10 irq cleared", 32'(irq_out), 32'h0);
        chk_rd("R10 status still low", 10'h014, 32'h0);
        tick();
        chk_rd("R10 status done", 10'h014, 32'h1);
        model_reset();
        for (int b = 0; b < NB; b++) chk_rd("R10 mask restored", 10'(10'h084 + 32*b), bank_mask(b));
        chk_rd("R10 level cleared", 10'h10C, 32'h0);
        chk_rd("R10 thr restored", 10'h068, 32'hFF);
        chk_rd("R10 syscfg cleared", 10'h010, 32'h0);
        chk_rd("R10 prot cleared", 10'h04C, 32'h0);
        chk_rd("R10 sorted restored", 10'h040, 32'hFFFF_FFFF);
        ticks(SC + 2);
        chk("R10 no sort while masked", 32'(irq_out), 32'h0);
        src_in = '0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule